// File: doc/BRIEF.md
# Shared 64-bit Comparator Timer

This block is a 64-bit up-counter that never resets itself while it runs. A single 64-bit comparator watches it. A slow-down divider sets the rate: the counter advances once every (P + 1) clocks, where P is an 8-bit field in the control word. When the comparator is armed and the count has reached or passed the compare value, a sticky pending flag sets. Software clears that flag by writing a 1 to it. The interrupt line is the pending flag gated by an interrupt-enable bit.

In auto-advance mode, each match adds a programmable step to the compare value. This gives a steady train of periodic events from a counter that is never reloaded. Several processors can share one counter, each with its own compare target. This model has one comparator. Software reaches the block through a flat 32-bit word register port with a write strobe and a read strobe. Reading the counter's low word captures its high word at the same moment, so a low-then-high read pair returns one coherent 64-bit value.

Top module: `cmp_timer`

## Requirements
- R1: After reset every register reads zero, the pending flag is clear and `irq` is low.
- R2: Word addresses: 0 count low, 1 count high, 2 control, 3 status, 4 compare low, 5 compare high, 6 step. Control bits: bit0 run, bit1 compare arm, bit2 interrupt enable, bit3 auto-advance, bits 15:8 divider P, and all other bits read 0. Status bit0 is the pending flag. Compare and step words can be written and read back at any time.
- R3: The count words take a write only while run is 0. A count write made while run is 1 is ignored.
- R4: While run is 1, the count rises by one every (P+1) clocks, with a full 64-bit carry between the words. The divider phase restarts when run goes low.
- R5: Address 1 returns the high count word as it stood at the last read of address 0 (a cycle with the read strobe high), not the live value.
- R6: In the cycle after compare arm is 1 and count >= compare, the pending flag sets. It stays set until it is cleared.
- R7: Writing status with bit0 = 1 clears the pending flag, but a match in the same cycle wins. Writing bit0 = 0 has no effect.
- R8: `irq` is high exactly when the pending flag and interrupt enable are both 1.
- R9: With auto-advance on, every cycle that matches replaces the compare value with compare + step (modulo 2^64).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (captures the high count word on a low-word read) |
| regAddr | input | 3 | Word address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr`, combinational |
| irq | output | 1 | Level interrupt |

## Verification
A bad divider phase or a lost carry shows up as a wrong count on the first read after counting stops, and the error is off by a whole number of ticks. A stale high-word shadow shows only when the high word changes between two low-word reads, so the bench changes it between reads on purpose. A compare value that is not advanced, or is advanced twice, shows as a wrong compare read one cycle after the match. In a running sequence it shows as a pending flag that returns too early or never returns.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  parameter int WORD_W = 32;
  parameter int CNT_W = 2 * WORD_W;
  parameter int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_CNT_LO = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_CNT_HI = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_CTRL   = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_STATUS = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_CMP_LO = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_CMP_HI = 3'd5;
  localparam logic [ADDR_W-1:0] ADR_STEP   = 3'd6;

  // control to datapath strobes
  typedef struct packed {
    logic              tick;
    logic              cntLoWr;
    logic              cntHiWr;
    logic              cmpLoWr;
    logic              cmpHiWr;
    logic              stepWr;
    logic              statusClr;
    logic              snapHi;
    logic              cmpEn;
    logic              autoAdv;
    logic [WORD_W-1:0] wrData;
  } dpStrobeT;

  // datapath state seen by control for readback
  typedef struct packed {
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  cmp;
    logic [WORD_W-1:0] step;
    logic [WORD_W-1:0] hiShadow;
    logic              pending;
  } dpViewT;
endpackage

// File: rtl/cmp_timer_ctrl.sv
module cmp_timer_ctrl
  import cmp_timer_pkg::*;
#(
  parameter int PRESC_W = 8,
  parameter int PRESC_LSB = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0] regWrData,
  output logic [WORD_W-1:0] regRdData,
  output logic              irq,
  input  dpViewT            view,
  output dpStrobeT          strobe
);
  logic               runEn, cmpEn, irqEn, autoAdv;
  logic [PRESC_W-1:0] presc, psCnt;
  logic               ctrlWr, tick;
  logic [WORD_W-1:0]  ctrlWord;

  assign ctrlWr = regWrEn && (regAddr == ADR_CTRL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runEn   <= 1'b0;
      cmpEn   <= 1'b0;
      irqEn   <= 1'b0;
      autoAdv <= 1'b0;
      presc   <= '0;
    end else if (ctrlWr) begin
      runEn   <= regWrData[0];
      cmpEn   <= regWrData[1];
      irqEn   <= regWrData[2];
      autoAdv <= regWrData[3];
      presc   <= regWrData[PRESC_LSB +: PRESC_W];
    end
  end

  // divider phase
  always_ff @(posedge clk) begin
    if (!rstN || !runEn) psCnt <= '0;
    else if (psCnt == presc) psCnt <= '0;
    else psCnt <= psCnt + 1'b1;
  end

  assign tick = runEn && (psCnt == presc);

  always_comb begin
    strobe.tick      = tick;
    strobe.cntLoWr   = regWrEn && (regAddr == ADR_CNT_LO) && !runEn;
    strobe.cntHiWr   = regWrEn && (regAddr == ADR_CNT_HI) && !runEn;
    strobe.cmpLoWr   = regWrEn && (regAddr == ADR_CMP_LO);
    strobe.cmpHiWr   = regWrEn && (regAddr == ADR_CMP_HI);
    strobe.stepWr    = regWrEn && (regAddr == ADR_STEP);
    strobe.statusClr = regWrEn && (regAddr == ADR_STATUS) && regWrData[0];
    strobe.snapHi    = regRdEn && (regAddr == ADR_CNT_LO);
    strobe.cmpEn     = cmpEn;
    strobe.autoAdv   = autoAdv;
    strobe.wrData    = regWrData;
  end

  always_comb begin
    ctrlWord = '0;
    ctrlWord[0] = runEn;
    ctrlWord[1] = cmpEn;
    ctrlWord[2] = irqEn;
    ctrlWord[3] = autoAdv;
    ctrlWord[PRESC_LSB +: PRESC_W] = presc;
  end

  always_comb begin
    case (regAddr)
      ADR_CNT_LO: regRdData = view.cnt[WORD_W-1:0];
      ADR_CNT_HI: regRdData = view.hiShadow;
      ADR_CTRL:   regRdData = ctrlWord;
      ADR_STATUS: regRdData = {{(WORD_W-1){1'b0}}, view.pending};
      ADR_CMP_LO: regRdData = view.cmp[WORD_W-1:0];
      ADR_CMP_HI: regRdData = view.cmp[CNT_W-1:WORD_W];
      ADR_STEP:   regRdData = view.step;
      default:    regRdData = '0;
    endcase
  end

  assign irq = view.pending && irqEn;

  // R4: with a divider above zero, ticks never come back to back
  a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rstN)
    (tick && presc != '0 && !ctrlWr) |=> !tick);

  // R3: a running counter never sees a count write strobe
  a_r3_no_write_running: assert property (@(posedge clk) disable iff (!rstN)
    (tick) |-> !(strobe.cntLoWr || strobe.cntHiWr));
endmodule

// File: rtl/cmp_timer_dp.sv
module cmp_timer_dp
  import cmp_timer_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  dpStrobeT strobe,
  output dpViewT   view
);
  logic [CNT_W-1:0]  cnt, cmp;
  logic [WORD_W-1:0] step, hiShadow;
  logic              pending, match;

  assign match = strobe.cmpEn && (cnt >= cmp);

  always_ff @(posedge clk) begin
    if (!rstN) cnt <= '0;
    else if (strobe.cntLoWr) cnt[WORD_W-1:0] <= strobe.wrData;
    else if (strobe.cntHiWr) cnt[CNT_W-1:WORD_W] <= strobe.wrData;
    else if (strobe.tick) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) cmp <= '0;
    else if (strobe.cmpLoWr) cmp[WORD_W-1:0] <= strobe.wrData;
    else if (strobe.cmpHiWr) cmp[CNT_W-1:WORD_W] <= strobe.wrData;
    else if (match && strobe.autoAdv) cmp <= cmp + CNT_W'(step);
  end

  always_ff @(posedge clk) begin
    if (!rstN) step <= '0;
    else if (strobe.stepWr) step <= strobe.wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) pending <= 1'b0;
    else if (match) pending <= 1'b1;
    else if (strobe.statusClr) pending <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) hiShadow <= '0;
    else if (strobe.snapHi) hiShadow <= cnt[CNT_W-1:WORD_W];
  end

  assign view.cnt      = cnt;
  assign view.cmp      = cmp;
  assign view.step     = step;
  assign view.hiShadow = hiShadow;
  assign view.pending  = pending;

  // R3: no tick and no write leaves the count frozen
  a_r3_count_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.tick && !strobe.cntLoWr && !strobe.cntHiWr) |=> $stable(cnt));

  // R4: a tick moves the count up by exactly one
  a_r4_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && !strobe.cntLoWr && !strobe.cntHiWr) |=> cnt == $past(cnt) + 1'b1);

  // R6: the pending flag is sticky until a clear
  a_r6_pending_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (pending && !strobe.statusClr) |=> pending);

  // R9: a match in auto-advance mode adds the step once
  a_r9_auto_advance: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cmpEn && strobe.autoAdv && cnt >= cmp && !strobe.cmpLoWr && !strobe.cmpHiWr)
    |=> cmp == $past(cmp) + CNT_W'($past(step)));
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0] regWrData,
  output logic [WORD_W-1:0] regRdData,
  output logic              irq
);
  dpStrobeT strobe;
  dpViewT   view;

  cmp_timer_ctrl #(.PRESC_W(8), .PRESC_LSB(8)) uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .irq(irq), .view(view), .strobe(strobe)
  );

  cmp_timer_dp uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .view(view)
  );
endmodule

// File: tb/tb_cmp_timer.sv
`timescale 1ns/1ps
module tb_cmp_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irq;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  typedef struct {
    string       req;
    bit          isIrq;
    logic [31:0] exp;
  } expItemT;
  expItemT expQ[$];

  always #2.5 clk = ~clk;

  cmp_timer dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData), .irq(irq)
  );

  // monitor: compare queued expectations late in the low phase
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (expQ.size() > 0) begin
        expItemT it;
        logic [31:0] act;
        it = expQ.pop_front();
        act = it.isIrq ? {31'b0, irq} : regRdData;
        nChecks++;
        if (act !== it.exp) begin
          nFails++;
          $display("FAIL %s: actual %08h expected %08h", it.req, act, it.exp);
        end
      end
    end
  end

  // drivers: each call starts and ends at a falling edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string req);
    expItemT it;
    regAddr = a; regRdEn = 1'b1;
    #1;
    it.req = req; it.isIrq = 1'b0; it.exp = e;
    expQ.push_back(it);
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic chkIrq(input logic e, input string req);
    expItemT it;
    #1;
    it.req = req; it.isIrq = 1'b1; it.exp = {31'b0, e};
    expQ.push_back(it);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R1 reset state
    rd(3'd2, 32'h0, "R1 ctrl");
    rd(3'd0, 32'h0, "R1 cnt lo");
    rd(3'd3, 32'h0, "R1 status");
    rd(3'd5, 32'h0, "R1 cmp hi");
    chkIrq(1'b0, "R1 irq");

    // R3 counter writable when stopped; R5 low read captures high
    wr(3'd0, 32'hFFFF_FFF0);
    wr(3'd1, 32'h0000_0001);
    rd(3'd0, 32'hFFFF_FFF0, "R3 cnt lo");
    rd(3'd1, 32'h0000_0001, "R3 cnt hi");

    // R4 count with carry: 21 ticks at divider 0
    wr(3'd2, 32'h1);
    idle(20);
    wr(3'd2, 32'h0);
    rd(3'd0, 32'h0000_0005, "R4 carry lo");
    rd(3'd1, 32'h0000_0002, "R4 carry hi");

    // R3 write while running ignored: 10 ticks
    wr(3'd2, 32'h1);
    wr(3'd0, 32'h0);
    idle(8);
    wr(3'd2, 32'h0);
    rd(3'd0, 32'h0000_000F, "R3 ignored lo");

    // R4 divider 3: 15 edges give 3 ticks; R2 ctrl readback
    wr(3'd2, 32'h0301);
    rd(3'd2, 32'h0000_0301, "R2 ctrl readback");
    idle(13);
    wr(3'd2, 32'h0);
    rd(3'd0, 32'h0000_0012, "R4 divider lo");

    // R5 shadow keeps the high word of the last low read
    rd(3'd0, 32'h0000_0012, "R5 lo");
    wr(3'd1, 32'h0000_0007);
    rd(3'd1, 32'h0000_0002, "R5 stale hi");
    rd(3'd0, 32'h0000_0012, "R5 lo again");
    rd(3'd1, 32'h0000_0007, "R5 fresh hi");

    // R6 compare at >= ; R8 irq gating
    wr(3'd4, 32'h0000_0013);
    wr(3'd5, 32'h0000_0007);
    wr(3'd2, 32'h2);
    idle(2);
    rd(3'd3, 32'h0, "R6 below cmp");
    wr(3'd0, 32'h0000_0013);
    idle(1);
    rd(3'd3, 32'h1, "R6 equal cmp");
    chkIrq(1'b0, "R8 irq disabled");
    wr(3'd2, 32'h6);
    chkIrq(1'b1, "R8 irq enabled");

    // R7 clear behaviour
    wr(3'd2, 32'h4);
    wr(3'd3, 32'h0);
    rd(3'd3, 32'h1, "R7 zero no effect");
    wr(3'd3, 32'h1);
    rd(3'd3, 32'h0, "R7 cleared");
    chkIrq(1'b0, "R8 irq after clear");
    wr(3'd2, 32'h6);
    idle(1);
    wr(3'd3, 32'h1);
    rd(3'd3, 32'h1, "R7 match beats clear");

    // R9 auto-advance with a stopped counter
    wr(3'd2, 32'h0);
    wr(3'd3, 32'h1);
    wr(3'd6, 32'h0000_0100);
    rd(3'd6, 32'h0000_0100, "R2 step readback");
    wr(3'd4, 32'h0000_0013);
    wr(3'd2, 32'hA);
    idle(2);
    rd(3'd4, 32'h0000_0113, "R9 single advance lo");
    rd(3'd5, 32'h0000_0007, "R9 single advance hi");
    rd(3'd3, 32'h1, "R9 pending");

    // R9 running: 384 ticks pass one more match
    wr(3'd3, 32'h1);
    wr(3'd2, 32'hB);
    idle(383);
    wr(3'd2, 32'hA);
    rd(3'd0, 32'h0000_0193, "R9 run count");
    rd(3'd4, 32'h0000_0213, "R9 run cmp");

    idle(2);
    finished = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule